// File: doc/BRIEF.md
# Instruction Line Request Retry Controller

This block sits between the threads of a multithreaded instruction fetch unit and the instruction cache. Each thread owns a one-line buffer, described by a stored line address and a valid bit. When a thread makes a fetch attempt, the block masks the offset bits off the program counter. It then either lets the fetch go ahead on the buffered line or offers a line request to the cache. The cache may refuse an offer. A refused request waits in one retry slot that all threads share, and a global blocked flag shuts every thread out of new requests until a retry signal from the cache lets the parked request through.

Squashes arrive one thread at a time. A squash forgets that thread's outstanding request and empties the retry slot if that thread owns it. Cache responses carry the thread id and the line address. A response that does not match the thread's outstanding request is dropped and counted. A matching response validates the line and, depending on the downstream stall for that thread, puts the thread in a completed or a stalled state.

The request port is a valid/ready stream with one difference from a held handshake. `req_valid` is offered for a single cycle and may fall without `req_ready`. A refused offer is not repeated on its own: it is parked, and it is offered again only in a cycle where `cache_retry` is high. The response port has no back-pressure. Fetch attempts take no handshake and are answered in the same cycle.

Top module: `ilr_ctrl`

## Requirements
- R1: An attempt whose thread buffer is valid and whose stored line address equals the attempt PC with its offset bits cleared raises `att_hit` in the same cycle and offers no request.
- R2: An attempt that misses offers a request in the same cycle, with `req_addr` equal to the PC with its offset bits cleared and `req_tid` equal to the thread. If it is accepted, the thread's line becomes invalid and the thread state becomes 1 (waiting for response) on the next cycle. `att_fail` stays low.
- R3: A refused miss raises `att_fail`. From the next cycle the request is parked, `blocked` is high, and the thread state is 2 (waiting for retry). At most one thread is ever in state 2.
- R4: While `blocked` is high, an attempt from any thread, including one that would hit, raises `att_fail` and offers no request.
- R5: In a cycle with `cache_retry` high and a parked request, that request is offered again with the same address and thread. If it is accepted, the slot empties, `blocked` falls and the owner's state becomes 1. If it is refused, `blocked` stays high.
- R6: `cache_retry` with an empty slot offers nothing and leaves `blocked` low.
- R7: A squash of the thread that owns the parked request empties the slot and clears `blocked`. The parked request is not offered, even when `cache_retry` is high in the same cycle. The thread state becomes 5 (squashed).
- R8: A squash of a thread waiting for a response forgets the request: a later response for that line is dropped and the line stays invalid.
- R9: A response is dropped when its thread is not in state 1 or its line address differs from the outstanding one. `drop_count` then rises by one on the next cycle and saturates at its maximum.
- R10: A matching response sets the line valid on the next cycle. The thread state becomes 3 (stalled) if that thread's bit of `stall_in` is high, else 4 (line ready).
- R11: While `irq_pending` is high, an attempt whose PC has both low two bits zero raises `att_fail` and offers no request. An attempt with either bit set proceeds normally.
- R12: A squash of a thread in the same cycle masks that thread's attempt (`att_fail`, no request) and drops a response to that thread.
- R13: A hit attempt puts the thread in state 0 (running) on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| att_valid | input | 1 | Fetch attempt this cycle |
| att_tid | input | TID_W | Thread making the attempt |
| att_pc | input | ADDR_W | Fetch PC of the attempt |
| att_hit | output | 1 | Buffered line usable, fetch goes ahead |
| att_fail | output | 1 | Attempt refused this cycle |
| req_valid | output | 1 | Line request offered (one-cycle offer) |
| req_ready | input | 1 | Cache accepts the offer |
| req_tid | output | TID_W | Thread of the offered request |
| req_addr | output | ADDR_W | Line-aligned address of the offered request |
| cache_retry | input | 1 | Cache invites resending the parked request |
| rsp_valid | input | 1 | Line response arrives |
| rsp_tid | input | TID_W | Thread the response belongs to |
| rsp_addr | input | ADDR_W | Address of the returned line |
| squash_valid | input | 1 | Squash of one thread |
| squash_tid | input | TID_W | Thread being squashed |
| irq_pending | input | 1 | Interrupt pending, holds off aligned fetches |
| stall_in | input | THREADS | Downstream stall per thread |
| thr_state | output | 3*THREADS | Per-thread state, 3 bits per thread |
| line_valid | output | THREADS | Per-thread buffer valid bit |
| blocked | output | 1 | Global block on new requests |
| drop_count | output | CNT_W | Saturating count of dropped responses |

## Verification
Two pairs of functions collide on purpose. A squash and a retry fall in the same cycle for the thread that owns the parked request. This is driven with `req_ready` high and judged correct only if no offer appears and `blocked` is low afterwards. The next miss from another thread is then accepted at once, which shows the slot is truly empty. A squash and a matching response also fall in the same cycle for one thread. The bench expects the drop counter to step and the line to stay invalid. A scoreboard queue holds every offer the stimulus should cause, so any extra or missing offer in these cycles is reported.

// File: rtl/ilr_pkg.sv
package ilr_pkg;
  typedef enum logic [2:0] {
    TS_RUN        = 3'd0,
    TS_WAIT_RSP   = 3'd1,
    TS_WAIT_RETRY = 3'd2,
    TS_STALLED    = 3'd3,
    TS_LINE_READY = 3'd4,
    TS_SQUASHED   = 3'd5
  } thr_state_e;
endpackage

// File: rtl/ilr_thread_ctx.sv
module ilr_thread_ctx
  import ilr_pkg::*;
#(
  parameter int TAG_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_squash,
  input  logic             ev_issue,
  input  logic             issue_acc,
  input  logic [TAG_W-1:0] issue_tag,
  input  logic             ev_resend_acc,
  input  logic             ev_rsp_ok,
  input  logic             rsp_stall,
  input  logic             ev_hit,
  output logic [TAG_W-1:0] tag_q,
  output logic             vld_q,
  output logic             out_q,
  output thr_state_e       state_q
);

  // priority: squash, new issue, resend accepted, response, hit
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q   <= '0;
      vld_q   <= 1'b0;
      out_q   <= 1'b0;
      state_q <= TS_RUN;
    end else if (ev_squash) begin
      out_q   <= 1'b0;
      state_q <= TS_SQUASHED;
    end else if (ev_issue) begin
      tag_q   <= issue_tag;
      vld_q   <= 1'b0;
      out_q   <= issue_acc;
      state_q <= issue_acc ? TS_WAIT_RSP : TS_WAIT_RETRY;
    end else if (ev_resend_acc) begin
      out_q   <= 1'b1;
      state_q <= TS_WAIT_RSP;
    end else if (ev_rsp_ok) begin
      vld_q   <= 1'b1;
      out_q   <= 1'b0;
      state_q <= rsp_stall ? TS_STALLED : TS_LINE_READY;
    end else if (ev_hit) begin
      state_q <= TS_RUN;
    end
  end

  assert_issue_invalidates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_issue && !ev_squash) |=> (!vld_q && tag_q == $past(issue_tag)));

  assert_rsp_validates_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rsp_ok && !ev_squash && !ev_issue && !ev_resend_acc) |=> (vld_q && !out_q));

  assert_squash_forgets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_squash |=> (!out_q && state_q == TS_SQUASHED));

endmodule

// File: rtl/ilr_retry_slot.sv
module ilr_retry_slot #(
  parameter int ADDR_W = 32,
  parameter int TID_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              park,
  input  logic [TID_W-1:0]  park_tid,
  input  logic [ADDR_W-1:0] park_addr,
  input  logic              resend_acc,
  input  logic              owner_squash,
  input  logic              retry_clear,
  output logic              full_q,
  output logic [TID_W-1:0]  tid_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              blocked_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q    <= 1'b0;
      tid_q     <= '0;
      addr_q    <= '0;
      blocked_q <= 1'b0;
    end else if (park) begin
      full_q    <= 1'b1;
      tid_q     <= park_tid;
      addr_q    <= park_addr;
      blocked_q <= 1'b1;
    end else if (owner_squash || resend_acc) begin
      full_q    <= 1'b0;
      blocked_q <= 1'b0;
    end else if (retry_clear) begin
      blocked_q <= 1'b0;
    end
  end

  assert_park_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    park |=> (full_q && blocked_q && addr_q == $past(park_addr)));

  assert_owner_squash_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_squash && !park) |=> (!full_q && !blocked_q));

endmodule

// File: rtl/ilr_drop_ctr.sv
module ilr_drop_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (inc && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assert_drop_counts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_drop_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/ilr_ctrl.sv
module ilr_ctrl
  import ilr_pkg::*;
#(
  parameter int THREADS    = 4,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int CNT_W      = 8,
  localparam int TID_W     = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int TAG_W     = ADDR_W - OFF_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 att_valid,
  input  logic [TID_W-1:0]     att_tid,
  input  logic [ADDR_W-1:0]    att_pc,
  output logic                 att_hit,
  output logic                 att_fail,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [TID_W-1:0]     req_tid,
  output logic [ADDR_W-1:0]    req_addr,
  input  logic                 cache_retry,
  input  logic                 rsp_valid,
  input  logic [TID_W-1:0]     rsp_tid,
  input  logic [ADDR_W-1:0]    rsp_addr,
  input  logic                 squash_valid,
  input  logic [TID_W-1:0]     squash_tid,
  input  logic                 irq_pending,
  input  logic [THREADS-1:0]   stall_in,
  output logic [3*THREADS-1:0] thr_state,
  output logic [THREADS-1:0]   line_valid,
  output logic                 blocked,
  output logic [CNT_W-1:0]     drop_count
);

  logic [TAG_W-1:0] tag_a [THREADS];
  logic [THREADS-1:0] vld_a;
  logic [THREADS-1:0] out_a;
  thr_state_e state_a [THREADS];
  logic [THREADS-1:0] wait_retry_v;

  logic              slot_full;
  logic [TID_W-1:0]  slot_tid;
  logic [ADDR_W-1:0] slot_addr;

  logic [TAG_W-1:0]  pc_tag;
  logic [ADDR_W-1:0] pc_line;
  logic              att_masked;
  logic              irq_hold;
  logic              buf_match;
  logic              need_req;
  logic              resend;
  logic              park;
  logic              owner_squash;
  logic              rsp_ok;
  logic              rsp_drop;
  logic              unused_bits;

  assign pc_tag  = att_pc[ADDR_W-1:OFF_W];
  assign pc_line = {pc_tag, {OFF_W{1'b0}}};

  // attempt decision
  always_comb begin
    att_masked = squash_valid && (squash_tid == att_tid);
    irq_hold   = irq_pending && (att_pc[1:0] == 2'b00);
    buf_match  = vld_a[att_tid] && (tag_a[att_tid] == pc_tag);
    att_hit    = att_valid && !att_masked && !blocked && !irq_hold && buf_match;
    need_req   = att_valid && !att_masked && !blocked && !irq_hold && !buf_match;
    att_fail   = att_valid && !att_hit && !(need_req && req_ready);
  end

  // retry slot resend and squash of its owner
  always_comb begin
    owner_squash = squash_valid && slot_full && (squash_tid == slot_tid);
    resend       = cache_retry && slot_full && !owner_squash;
    park         = need_req && !req_ready;
  end

  // request stream: a new miss and a resend never coincide (slot full implies blocked)
  always_comb begin
    req_valid = need_req || resend;
    req_tid   = resend ? slot_tid  : att_tid;
    req_addr  = resend ? slot_addr : pc_line;
  end

  // response match
  always_comb begin
    rsp_ok = rsp_valid
          && (state_a[rsp_tid] == TS_WAIT_RSP)
          && out_a[rsp_tid]
          && (tag_a[rsp_tid] == rsp_addr[ADDR_W-1:OFF_W])
          && !(squash_valid && squash_tid == rsp_tid);
    rsp_drop = rsp_valid && !rsp_ok;
  end

  assign unused_bits = ^{att_pc[OFF_W-1:0], rsp_addr[OFF_W-1:0]};

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    logic ev_sq, ev_iss, ev_rs, ev_rsp, ev_ht;
    assign ev_sq  = squash_valid && (squash_tid == TID_W'(t));
    assign ev_iss = need_req && (att_tid == TID_W'(t));
    assign ev_rs  = resend && req_ready && (slot_tid == TID_W'(t));
    assign ev_rsp = rsp_ok && (rsp_tid == TID_W'(t));
    assign ev_ht  = att_hit && (att_tid == TID_W'(t));

    ilr_thread_ctx #(.TAG_W(TAG_W)) u_ctx (
      .clk          (clk),
      .rst_n        (rst_n),
      .ev_squash    (ev_sq),
      .ev_issue     (ev_iss),
      .issue_acc    (req_ready),
      .issue_tag    (pc_tag),
      .ev_resend_acc(ev_rs),
      .ev_rsp_ok    (ev_rsp),
      .rsp_stall    (stall_in[t]),
      .ev_hit       (ev_ht),
      .tag_q        (tag_a[t]),
      .vld_q        (vld_a[t]),
      .out_q        (out_a[t]),
      .state_q      (state_a[t])
    );

    assign thr_state[3*t +: 3] = state_a[t];
    assign line_valid[t]       = vld_a[t];
    assign wait_retry_v[t]     = (state_a[t] == TS_WAIT_RETRY);
  end

  ilr_retry_slot #(.ADDR_W(ADDR_W), .TID_W(TID_W)) u_slot (
    .clk         (clk),
    .rst_n       (rst_n),
    .park        (park),
    .park_tid    (att_tid),
    .park_addr   (pc_line),
    .resend_acc  (resend && req_ready),
    .owner_squash(owner_squash),
    .retry_clear (cache_retry && !slot_full),
    .full_q      (slot_full),
    .tid_q       (slot_tid),
    .addr_q      (slot_addr),
    .blocked_q   (blocked)
  );

  ilr_drop_ctr #(.CNT_W(CNT_W)) u_drop (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (rsp_drop),
    .cnt_q(drop_count)
  );

  assert_slot_implies_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_full |-> blocked);

  assert_single_retry_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wait_retry_v) <= 1);

  assert_quiet_when_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && blocked) |-> cache_retry);

  assert_hit_no_request_R1: assert property (@(posedge clk) disable iff (!rst_n)
    att_hit |-> (!req_valid && !att_fail));

  assert_hit_to_run_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (att_hit && !(squash_valid && squash_tid == att_tid)) |=> (thr_state[3*$past(att_tid) +: 3] == 3'd0));

endmodule

// File: tb/ilr_ctrl_test.sv
module ilr_ctrl_test;
  localparam int THREADS = 4;
  localparam int ADDR_W  = 32;
  localparam int CNT_W   = 8;
  localparam int TID_W   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic att_valid; logic [TID_W-1:0] att_tid; logic [ADDR_W-1:0] att_pc;
  logic att_hit, att_fail;
  logic req_valid, req_ready; logic [TID_W-1:0] req_tid; logic [ADDR_W-1:0] req_addr;
  logic cache_retry;
  logic rsp_valid; logic [TID_W-1:0] rsp_tid; logic [ADDR_W-1:0] rsp_addr;
  logic squash_valid; logic [TID_W-1:0] squash_tid;
  logic irq_pending;
  logic [THREADS-1:0] stall_in;
  logic [3*THREADS-1:0] thr_state;
  logic [THREADS-1:0] line_valid;
  logic blocked;
  logic [CNT_W-1:0] drop_count;

  int n_tests = 0;
  int n_fail  = 0;
  logic [33:0] exp_q [$];

  always #10 clk = ~clk;

  ilr_ctrl #(.THREADS(THREADS), .ADDR_W(ADDR_W), .LINE_BYTES(64), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .att_valid(att_valid), .att_tid(att_tid), .att_pc(att_pc),
    .att_hit(att_hit), .att_fail(att_fail),
    .req_valid(req_valid), .req_ready(req_ready), .req_tid(req_tid), .req_addr(req_addr),
    .cache_retry(cache_retry),
    .rsp_valid(rsp_valid), .rsp_tid(rsp_tid), .rsp_addr(rsp_addr),
    .squash_valid(squash_valid), .squash_tid(squash_tid),
    .irq_pending(irq_pending), .stall_in(stall_in),
    .thr_state(thr_state), .line_valid(line_valid),
    .blocked(blocked), .drop_count(drop_count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] st(input int t);
    return thr_state[3*t +: 3];
  endfunction

  // scoreboard monitor: every offer must match the next expected one
  always @(negedge clk) begin
    if (rst_n && req_valid) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R4 unexpected offer actual=%0h expected=none", req_addr);
      end else begin
        logic [33:0] e;
        e = exp_q.pop_front();
        check("R2/R5 offer tid+addr", {30'd0, req_tid}, {30'd0, e[33:32]});
        check("R2/R5 offer addr", req_addr, e[31:0]);
      end
    end
  end

  task automatic expect_offer(input logic [1:0] t, input logic [31:0] a);
    exp_q.push_back({t, a});
  endtask

  task automatic idle();
    att_valid = 0; att_tid = 0; att_pc = 0; req_ready = 0; cache_retry = 0;
    rsp_valid = 0; rsp_tid = 0; rsp_addr = 0; squash_valid = 0; squash_tid = 0;
    irq_pending = 0; stall_in = '0;
  endtask

  task automatic to_neg(); @(negedge clk); endtask
  task automatic next(); @(posedge clk); #2; idle(); endtask

  task automatic attempt(input logic [1:0] t, input logic [31:0] pc, input logic rdy);
    att_valid = 1; att_tid = t; att_pc = pc; req_ready = rdy;
  endtask

  task automatic respond(input logic [1:0] t, input logic [31:0] a);
    rsp_valid = 1; rsp_tid = t; rsp_addr = a;
  endtask

  initial begin
    #(20 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // reset state
    check("reset blocked", blocked, 0);
    check("reset line_valid", line_valid, 0);
    check("reset thr_state", thr_state, 0);
    check("reset drop_count", drop_count, 0);

    // R2 miss accepted
    attempt(0, 32'h1004, 1); expect_offer(0, 32'h1000);
    to_neg(); check("R2 att_fail", att_fail, 0); check("R2 att_hit", att_hit, 0);
    next(); check("R2 state wait rsp", st(0), 1); check("R2 line invalid", line_valid[0], 0);

    // R10 matching response, no stall
    respond(0, 32'h1010);
    next(); check("R10 line valid", line_valid[0], 1); check("R10 state ready", st(0), 4);

    // R1 / R13 hit
    attempt(0, 32'h1030, 1);
    to_neg(); check("R1 att_hit", att_hit, 1); check("R1 req_valid", req_valid, 0);
    next(); check("R13 state run", st(0), 0);

    // R11 interrupt hold
    attempt(1, 32'h2000, 1); irq_pending = 1;
    to_neg(); check("R11 aligned fail", att_fail, 1); check("R11 no offer", req_valid, 0);
    next(); check("R11 state unchanged", st(1), 0);
    attempt(1, 32'h2002, 1); irq_pending = 1; expect_offer(1, 32'h2000);
    to_neg(); check("R11 unaligned proceeds", att_fail, 0);
    next(); check("R11 state wait rsp", st(1), 1);

    // R10 response with stall
    respond(1, 32'h2000); stall_in = 4'b0010;
    next(); check("R10 state stalled", st(1), 3); check("R10 line valid t1", line_valid[1], 1);

    // R3 refusal
    attempt(2, 32'h3000, 0); expect_offer(2, 32'h3000);
    to_neg(); check("R3 att_fail", att_fail, 1);
    next(); check("R3 blocked", blocked, 1); check("R3 state wait retry", st(2), 2);

    // R4 blocked
    attempt(3, 32'h4000, 1);
    to_neg(); check("R4 miss fail", att_fail, 1); check("R4 no offer", req_valid, 0);
    next();
    attempt(0, 32'h1000, 1);
    to_neg(); check("R4 hit also fails", att_fail, 1); check("R4 no hit", att_hit, 0);
    next(); check("R4 still blocked", blocked, 1);

    // R5 retry refused then accepted
    cache_retry = 1; req_ready = 0; expect_offer(2, 32'h3000);
    next(); check("R5 refused stays blocked", blocked, 1); check("R5 state", st(2), 2);
    cache_retry = 1; req_ready = 1; expect_offer(2, 32'h3000);
    next(); check("R5 blocked cleared", blocked, 0); check("R5 state wait rsp", st(2), 1);

    // R6 retry with empty slot
    cache_retry = 1; req_ready = 1;
    to_neg(); check("R6 no offer", req_valid, 0);
    next(); check("R6 blocked low", blocked, 0);

    // R8 squash while waiting, later response dropped
    squash_valid = 1; squash_tid = 2;
    next(); check("R8 state squashed", st(2), 5);
    respond(2, 32'h3000);
    next(); check("R8 drop counted", drop_count, 1); check("R8 line invalid", line_valid[2], 0);

    // R7 owner squash with retry in same cycle
    attempt(3, 32'h4000, 0); expect_offer(3, 32'h4000);
    next(); check("R7 precondition blocked", blocked, 1);
    squash_valid = 1; squash_tid = 3; cache_retry = 1; req_ready = 1;
    to_neg(); check("R7 no resend", req_valid, 0);
    next(); check("R7 blocked cleared", blocked, 0); check("R7 state squashed", st(3), 5);
    attempt(0, 32'h5000, 1); expect_offer(0, 32'h5000);
    to_neg(); check("R7 slot empty, new miss ok", att_fail, 0);
    next(); check("R7 state t0 wait", st(0), 1);

    // R9 mismatches
    respond(0, 32'h6000);
    next(); check("R9 addr mismatch drop", drop_count, 2); check("R9 state kept", st(0), 1);
    respond(3, 32'h4000);
    next(); check("R9 wrong state drop", drop_count, 3);
    respond(0, 32'h5000);
    next(); check("R9 match not dropped", drop_count, 3); check("R10 line t0", line_valid[0], 1);

    // R12 squash masks attempt and response
    attempt(1, 32'h7000, 1); squash_valid = 1; squash_tid = 1;
    to_neg(); check("R12 masked attempt fails", att_fail, 1); check("R12 no offer", req_valid, 0);
    next(); check("R12 state squashed", st(1), 5);
    attempt(0, 32'h8000, 1); expect_offer(0, 32'h8000);
    next();
    respond(0, 32'h8000); squash_valid = 1; squash_tid = 0;
    next(); check("R12 response dropped", drop_count, 4); check("R12 line invalid", line_valid[0], 0);
    check("R12 state t0", st(0), 5);

    // R9 saturation
    for (int i = 0; i < 260; i++) begin
      respond(3, 32'h4000);
      next();
    end
    check("R9 saturates", drop_count, 255);

    check("scoreboard drained", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule